// File: doc/BRIEF.md
# Four-Channel Interleaved DS1 Demultiplexer

This block takes one aggregate serial stream that carries four DS1 channels interleaved bit by bit. Each channel bit occupies two consecutive slots. For the framing bit and payload bits 1 to 4 of a timeslot, the second slot is a repeat and is thrown away. For payload bits 5 to 8, the second slot carries that channel's robbed-bit signaling bit A, B, C or D. A one-clock sync pulse marks the first slot of a frame, which is the framing bit of channel 0.

The block runs on the aggregate clock alone. For each channel it produces a recovered bit with a valid strobe, which is a clock enable at one eighth of the aggregate rate. It also flags the framing bit. Once the D slot of a timeslot has been sampled, it presents that timeslot's four-bit signaling nibble with a strobe, together with the timeslot index.

The output streams are valid-only and have no ready input. The aggregate line cannot be stalled, so there is no back-pressure: a consumer must take each strobe in the clock it appears. A sync that arrives where the block did not expect a frame start realigns the slot count at once and raises a one-clock misalignment pulse.

Top module: `ds1_interleave_demux`

## Requirements
- R1: After a synchronous active-high reset, and until the first sync pulse, `lane_valid`, `lane_fstart`, `sig_valid` and `misalign` stay 0.
- R2: A sync sampled together with a slot makes that slot frame slot 0. One clock later, channel 0 shows that slot's bit with `lane_valid[0]` and `lane_fstart[0]` high.
- R3: Frame slot s belongs to channel (s mod 8)/2. When s mod 8 is even, the sampled bit appears on `lane_bit[c]` with a one-clock `lane_valid[c]`, one clock after it is sampled. At most one lane is valid in any clock, and each lane is valid once every 8 clocks.
- R4: Odd slots that repeat the framing bit or payload bits 1 to 4 are discarded. They raise no strobe and leave `lane_bit` unchanged.
- R5: Frame bit b ≥ 1 is payload bit ((b−1) mod 8)+1 of timeslot (b−1)/8. The odd slot after payload bits 5, 6, 7 and 8 carries signaling A, B, C and D. One clock after the D slot, `sig_valid[c]` pulses, `sig_nibble[4c+3:4c]` = {A,B,C,D} (A in bit 3), and `sig_ts` holds the timeslot index.
- R6: `lane_fstart[c]` is high only together with `lane_valid[c]` for the framing bit, which is frame bit 0.
- R7: Once locked, the frame of 8·(8·TIMESLOTS+1) slots wraps to slot 0 on its own, with no further sync.
- R8: A sync on the slot the block already expects as slot 0 leaves `misalign` low. A sync on any other slot realigns the count and pulses `misalign` for one clock, at the same time as channel 0's framing-bit strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Aggregate-rate clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Aggregate serial data |
| ser_sync | input | 1 | Frame-start pulse on slot 0 |
| lane_bit | output | NUM_CH | Recovered bit per channel |
| lane_valid | output | NUM_CH | One-clock strobe per recovered bit |
| lane_fstart | output | NUM_CH | Marks the framing bit on a lane |
| sig_nibble | output | 4*NUM_CH | Signaling nibble per channel, A in the top bit |
| sig_valid | output | NUM_CH | Strobe for a new nibble |
| sig_ts | output | clog2(TIMESLOTS) | Timeslot index of the latest nibble |
| misalign | output | 1 | One-clock pulse on an unexpected sync |

## Verification
The bench builds the block with its defaults: NUM_CH = 4 and TIMESLOTS = 24, which gives a 1544-slot frame. With these values it can run whole frames back to back, both with a sync on every frame and free-running across the wrap. It can therefore check every timeslot's nibble up to index 23 and every lane's framing bit. Filler slots are driven both as true repeats and as inverted copies, so that a captured repeat would show up on the lane outputs.

// File: rtl/ds1_demux_pkg.sv
package ds1_demux_pkg;
  localparam int unsigned SLOT_BITS_PER_TS = 8;
  localparam int unsigned SIG_BITS = 4;
  localparam int unsigned CH_IDX_W = 4;
  localparam int unsigned TS_IDX_W = 8;

  typedef struct packed {
    logic                active;
    logic                second;
    logic                is_fbit;
    logic [CH_IDX_W-1:0] ch;
    logic [TS_IDX_W-1:0] ts;
    logic [2:0]          pos;
    logic                sig_cap;
    logic [1:0]          sig_idx;
    logic                sig_done;
  } slot_info_t;
endpackage

// File: rtl/ds1_slot_tracker.sv
module ds1_slot_tracker #(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned FRAME_BITS = 193
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic active_o,
  output logic locked_o,
  output logic [$clog2(2*NUM_CH)-1:0] ph_o,
  output logic [$clog2(FRAME_BITS)-1:0] bit_o,
  output logic misalign_o
);
  localparam int unsigned PAIR_SLOTS = 2 * NUM_CH;
  localparam int unsigned PH_W = $clog2(PAIR_SLOTS);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);

  logic             locked_q;
  logic [PH_W-1:0]  ph_q, ph_nx, ph_cur;
  logic [BIT_W-1:0] bit_q, bit_nx, bit_cur;

  // position of the slot following the previous one
  always_comb begin
    if (ph_q == PH_W'(PAIR_SLOTS - 1)) begin
      ph_nx  = '0;
      bit_nx = (bit_q == BIT_W'(FRAME_BITS - 1)) ? '0 : bit_q + BIT_W'(1);
    end else begin
      ph_nx  = ph_q + PH_W'(1);
      bit_nx = bit_q;
    end
  end

  // position of the slot sampled in this cycle
  always_comb begin
    if (sync_i) begin
      ph_cur  = '0;
      bit_cur = '0;
    end else begin
      ph_cur  = ph_nx;
      bit_cur = bit_nx;
    end
  end

  assign active_o = sync_i | locked_q;
  assign locked_o = locked_q;
  assign ph_o     = ph_cur;
  assign bit_o    = bit_cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q   <= 1'b0;
      ph_q       <= '0;
      bit_q      <= '0;
      misalign_o <= 1'b0;
    end else begin
      locked_q   <= locked_q | sync_i;
      misalign_o <= sync_i && locked_q && ((ph_nx != '0) || (bit_nx != '0));
      if (active_o) begin
        ph_q  <= ph_cur;
        bit_q <= bit_cur;
      end
    end
  end

  // R8: a misalignment pulse needs a sync that met an already locked count
  assert_misalign_cause_R8: assert property (@(posedge clk) disable iff (rst)
    misalign_o |-> ($past(sync_i) && $past(locked_q)));

  // R1: the lock is never lost without reset
  assert_lock_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> locked_q);
endmodule

// File: rtl/ds1_slot_decode.sv
module ds1_slot_decode
  import ds1_demux_pkg::*;
#(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned FRAME_BITS = 193
) (
  input  logic                          active_i,
  input  logic [$clog2(2*NUM_CH)-1:0]   ph_i,
  input  logic [$clog2(FRAME_BITS)-1:0] bit_i,
  output slot_info_t                    info_o
);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);

  logic [BIT_W-1:0] k;

  always_comb begin
    k                = bit_i - BIT_W'(1);
    info_o           = '0;
    info_o.active    = active_i;
    info_o.second    = ph_i[0];
    info_o.ch        = CH_IDX_W'(ph_i >> 1);
    info_o.is_fbit   = (bit_i == '0);
    info_o.pos       = k[2:0];
    info_o.ts        = TS_IDX_W'(k >> 3);
    info_o.sig_idx   = k[1:0];
    info_o.sig_cap   = active_i && ph_i[0] && !info_o.is_fbit && k[2];
    info_o.sig_done  = info_o.sig_cap && (k[2:0] == 3'd7);
  end
endmodule

// File: rtl/ds1_lane.sv
module ds1_lane
  import ds1_demux_pkg::*;
#(
  parameter int unsigned CH_ID = 0
) (
  input  logic       clk,
  input  logic       rst,
  input  slot_info_t info_i,
  input  logic       din,
  output logic       bit_o,
  output logic       valid_o,
  output logic       fstart_o,
  output logic [SIG_BITS-1:0] nib_o,
  output logic       nvalid_o
);
  logic mine, take, cap;
  logic [SIG_BITS-1:0] acc;

  assign mine = info_i.active && (info_i.ch == CH_IDX_W'(CH_ID));
  assign take = mine && !info_i.second;
  assign cap  = mine && info_i.sig_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_o    <= 1'b0;
      valid_o  <= 1'b0;
      fstart_o <= 1'b0;
      nib_o    <= '0;
      nvalid_o <= 1'b0;
      acc      <= '0;
    end else begin
      valid_o  <= take;
      fstart_o <= take && info_i.is_fbit;
      nvalid_o <= cap && info_i.sig_done;
      if (take) bit_o <= din;
      if (cap) acc[2'd3 - info_i.sig_idx] <= din;
      if (cap && info_i.sig_done) nib_o <= {acc[3:1], din};
    end
  end

  // R3: a lane strobe never lasts two clocks
  assert_lane_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  // R6: the frame flag only rides on a bit strobe
  assert_fstart_with_bit_R6: assert property (@(posedge clk) disable iff (rst)
    fstart_o |-> valid_o);

  // R5: the nibble strobe follows payload bit 8 of the same lane
  assert_nibble_after_bit_R5: assert property (@(posedge clk) disable iff (rst)
    nvalid_o |-> ($past(valid_o) && !$past(fstart_o)));
endmodule

// File: rtl/ds1_interleave_demux.sv
module ds1_interleave_demux
  import ds1_demux_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned TIMESLOTS = 24
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ser_bit,
  input  logic                          ser_sync,
  output logic [NUM_CH-1:0]             lane_bit,
  output logic [NUM_CH-1:0]             lane_valid,
  output logic [NUM_CH-1:0]             lane_fstart,
  output logic [SIG_BITS*NUM_CH-1:0]    sig_nibble,
  output logic [NUM_CH-1:0]             sig_valid,
  output logic [$clog2(TIMESLOTS)-1:0]  sig_ts,
  output logic                          misalign
);
  localparam int unsigned FRAME_BITS = TIMESLOTS * SLOT_BITS_PER_TS + 1;
  localparam int unsigned PH_W  = $clog2(2 * NUM_CH);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);
  localparam int unsigned TS_W  = $clog2(TIMESLOTS);

  logic             active, locked;
  logic [PH_W-1:0]  ph;
  logic [BIT_W-1:0] bitn;
  slot_info_t       info;

  ds1_slot_tracker #(.NUM_CH(NUM_CH), .FRAME_BITS(FRAME_BITS)) u_track (
    .clk(clk), .rst(rst), .sync_i(ser_sync), .active_o(active),
    .locked_o(locked), .ph_o(ph), .bit_o(bitn), .misalign_o(misalign)
  );

  ds1_slot_decode #(.NUM_CH(NUM_CH), .FRAME_BITS(FRAME_BITS)) u_dec (
    .active_i(active), .ph_i(ph), .bit_i(bitn), .info_o(info)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    ds1_lane #(.CH_ID(c)) u_lane (
      .clk(clk), .rst(rst), .info_i(info), .din(ser_bit),
      .bit_o(lane_bit[c]), .valid_o(lane_valid[c]), .fstart_o(lane_fstart[c]),
      .nib_o(sig_nibble[SIG_BITS*c +: SIG_BITS]), .nvalid_o(sig_valid[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sig_ts <= '0;
    else if (info.sig_done) sig_ts <= info.ts[TS_W-1:0];
  end

  // R1: nothing is strobed before the first sync
  assert_quiet_until_sync_R1: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (lane_valid == '0 && sig_valid == '0));

  // R2: a sync makes channel 0 deliver its framing bit next clock
  assert_sync_starts_frame_R2: assert property (@(posedge clk) disable iff (rst)
    ser_sync |=> (lane_valid[0] && lane_fstart[0]));

  // R3: lanes take turns, never two at once
  assert_single_lane_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_valid));

  // R5: a reported timeslot index is always in range
  assert_ts_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    (sig_valid != '0) |-> (int'(sig_ts) < TIMESLOTS));

  // R8: a misalignment pulse coincides with channel 0's framing strobe
  assert_misalign_at_frame_R8: assert property (@(posedge clk) disable iff (rst)
    misalign |-> lane_fstart[0]);
endmodule

// File: tb/tb_ds1_interleave_demux.sv
module tb_ds1_interleave_demux;
  localparam int NUM_CH    = 4;
  localparam int TIMESLOTS = 24;
  localparam int PAIR      = 2 * NUM_CH;
  localparam int FSLOTS    = PAIR * (TIMESLOTS * 8 + 1);
  localparam int TS_W      = $clog2(TIMESLOTS);
  localparam time CLK_PERIOD = 10ns;

  // {payload seed, signaling seed, invert filler, sync on slot 0}
  localparam logic [65:0] VEC [0:4] = '{
    {32'h0000_0001, 32'h0000_0002, 1'b0, 1'b1},
    {32'h0000_00A5, 32'h0000_005A, 1'b1, 1'b0},
    {32'h0000_1234, 32'h0000_BEEF, 1'b1, 1'b1},
    {32'h0000_CAFE, 32'h0000_0000, 1'b0, 1'b0},
    {32'hFFFF_0F0F, 32'h3C3C_A5A5, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst, ser_bit, ser_sync;
  logic [NUM_CH-1:0]   lane_bit, lane_valid, lane_fstart, sig_valid;
  logic [4*NUM_CH-1:0] sig_nibble;
  logic [TS_W-1:0]     sig_ts;
  logic                misalign;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit   pend;
  int   e_ph, e_b;
  logic e_bit, e_mis;
  logic [3:0] nibacc [NUM_CH];
  logic       lastfirst [NUM_CH];

  always #(CLK_PERIOD/2) clk = ~clk;

  ds1_interleave_demux #(.NUM_CH(NUM_CH), .TIMESLOTS(TIMESLOTS)) dut (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .ser_sync(ser_sync),
    .lane_bit(lane_bit), .lane_valid(lane_valid), .lane_fstart(lane_fstart),
    .sig_nibble(sig_nibble), .sig_valid(sig_valid), .sig_ts(sig_ts),
    .misalign(misalign)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic hbit(input int unsigned seed, input int c, input int ts, input int p);
    int unsigned x;
    x = (seed ^ ((c << 12) | (ts << 4) | p)) * 32'h9E3779B1;
    x = x ^ (x >> 15);
    return x[7];
  endfunction

  function automatic logic slot_val(input int s, input int unsigned sp,
                                    input int unsigned ss, input bit inv);
    int b, ph, c, p, ts;
    bit sec;
    logic f;
    b = s / PAIR; ph = s % PAIR; c = ph / 2; sec = ph[0];
    if (b == 0) begin
      f = hbit(sp, c, 200, 0);
      return sec ? (f ^ inv) : f;
    end
    p = (b - 1) % 8; ts = (b - 1) / 8;
    if (!sec) return hbit(sp, c, ts, p + 1);
    if (p >= 4) return hbit(ss, c, ts, p - 4);
    return hbit(sp, c, ts, p + 1) ^ inv;
  endfunction

  // compare outputs against the slot driven one clock earlier
  task automatic verify_prev();
    int c, p;
    if (!pend) return;
    c = (e_ph % PAIR) / 2;
    if (e_ph % 2 == 0) begin
      chk(e_b == 0 ? "R2" : "R3", lane_valid, 32'(1) << c);
      chk(e_b == 0 ? "R2" : "R3", lane_bit[c], e_bit);
      chk(e_b == 0 ? "R6" : "R6 (payload)", lane_fstart, e_b == 0 ? (32'(1) << c) : 0);
    end else begin
      chk("R4", lane_valid, 0);
      chk("R4", lane_bit[c], lastfirst[c]);
      p = (e_b - 1) % 8;
      if (e_b >= 1 && p == 7) begin
        chk("R5", sig_valid, 32'(1) << c);
        chk("R5", sig_nibble[4*c +: 4], nibacc[c]);
        chk("R5", sig_ts, (e_b - 1) / 8);
      end else begin
        chk("R5", sig_valid, 0);
      end
    end
    chk(e_mis ? "R8" : "R8 (R7 wrap)", misalign, e_mis);
  endtask

  task automatic drive_slot(input int s, input int unsigned sp, input int unsigned ss,
                            input bit inv, input bit sync, input bit mis);
    logic v;
    int ph, b, c, p;
    @(negedge clk);
    verify_prev();
    v = slot_val(s, sp, ss, inv);
    ser_bit = v; ser_sync = sync;
    ph = s % PAIR; b = s / PAIR; c = ph / 2;
    e_ph = ph; e_b = b; e_bit = v; e_mis = mis;
    if (ph % 2 == 0) lastfirst[c] = v;
    else if (b >= 1) begin
      p = (b - 1) % 8;
      if (p >= 4) nibacc[c][3 - (p - 4)] = v;
    end
    pend = 1;
  endtask

  task automatic finish_run();
    @(negedge clk);
    verify_prev();
    pend = 0;
    ser_sync = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    pend = 0; rst = 1; ser_bit = 0; ser_sync = 0;
    repeat (3) @(negedge clk);
    chk("R1", lane_valid, 0);
    chk("R1", sig_valid, 0);
    chk("R1", misalign, 0);
    rst = 0;

    // table walk: whole frames, sync on some, free-running on others (R7)
    for (int i = 0; i < 5; i++) begin
      for (int s = 0; s < FSLOTS; s++)
        drive_slot(s, VEC[i][65:34], VEC[i][33:2], VEC[i][1], VEC[i][0] && s == 0, 1'b0);
    end

    // R8: stray sync at slot 100 realigns and pulses misalign
    for (int s = 0; s < 100; s++)
      drive_slot(s, 32'h77, 32'h88, 1'b0, 1'b0, 1'b0);
    for (int s = 0; s < FSLOTS; s++)
      drive_slot(s, 32'h99, 32'h66, 1'b1, s == 0, s == 0);
    finish_run();

    // R1: reset mid-stream, then no strobes without a sync
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1", lane_valid, 0);
    chk("R1", sig_valid, 0);
    for (int k = 0; k < 40; k++) begin
      ser_bit = k[0] ^ k[2];
      @(negedge clk);
      chk("R1", lane_valid | lane_fstart, 0);
      chk("R1", {sig_valid, misalign}, 0);
    end

    // R1/R2: relock after reset
    for (int s = 0; s < 3 * PAIR; s++)
      drive_slot(s, 32'h5, 32'h6, 1'b0, s == 0, 1'b0);
    finish_run();

    done = 1;
    summary();
    $finish;
  end
endmodule